// File: doc/BRIEF.md
# Streaming LEB128 Immediate Decoder

This block turns a little-endian base-128 (LEB128) integer, presented one byte per clock on a byte-valid strobe, into a 32-bit value. Every byte adds seven payload bits above those already collected, and bit 7 of each byte says whether another byte follows. A signed-mode select picks between two's-complement extension, with the sign bit chosen from the number of bytes consumed, and plain zero-extension.

A clear input starts each new field. It resets the accumulator, the shift position and the byte count, so one instance can decode fields that follow each other directly. The byte that ends the field raises a one-cycle done strobe in the cycle it is presented, with the finished value on the result port. That value then stays there until the next clear. A fifth byte that still asks for more is malformed. It sets a sticky overflow flag and no done is given.

Top module: `leb_stream_dec`

## Requirements
- R1: Byte k of a field (counting from 0) places its bits [6:0] at result bits [7k+6:7k]. Bit 7 set means another byte follows. The byte with bit 7 clear raises done in the same cycle it is presented, and result shows the decoded value in that cycle.
- R2: With sgn_mode=1, a field of 1, 2, 3 or 4 bytes is sign-extended from result bit 6, 13, 20 or 27 respectively.
- R3: With sgn_mode=0, every result bit above the last payload bit received is zero.
- R4: In a five-byte field, only bits [3:0] of the fifth byte reach the result (as bits [31:28]), and its bits [6:4] are ignored. No extension is applied in either mode.
- R5: A fifth byte with bit 7 set gives no done. From the next cycle, ovf_err is 1, and it stays 1 until clr, whatever bytes arrive in the meantime.
- R6: done lasts one cycle per field. After done, result holds the decoded value, and further valid bytes are ignored (no done, result unchanged) until clr.
- R7: clr returns the decoder to its empty state from the next cycle: ovf_err is 0 and result is 0 until the next done. A byte presented in the same cycle as clr is discarded. Cycles with byte_vld low do not change the decode.
- R8: After a synchronous reset (rst high at a clock edge), done=0, ovf_err=0 and result=0, and the decoder accepts a new field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Start a new field; clears all decode state |
| byte_vld | input | 1 | byte_in carries a field byte this cycle |
| byte_in | input | 8 | Field byte: [6:0] payload, [7] more-bytes flag |
| sgn_mode | input | 1 | 1 = sign-extend by byte count, 0 = zero-extend |
| done | output | 1 | Field completed by this cycle's byte |
| result | output | 32 | Decoded value (live on done, then held) |
| ovf_err | output | 1 | Sticky: fifth byte still had its more-bytes flag |

## Verification
The properties expect every input to be at a known level after reset. They also expect clr to be a synchronous level sampled at the clock, and they accept that sgn_mode is read only in the cycle of the final byte. The stimulus changes every input on the falling edge only. It keeps byte_in and sgn_mode at defined values even when byte_vld is low, and it holds sgn_mode steady across each field. Because done and result settle combinationally from the byte being presented, the bench samples them one nanosecond after it drives the byte, which is before the rising edge that accepts it.

// File: rtl/leb_pkg.sv
`timescale 1ns/1ps
package leb_pkg;

    // payload bits carried by each stream byte
    localparam int GRP_W = 7;

    typedef enum logic [1:0] {
        PH_RUN  = 2'd0,   // collecting bytes
        PH_DONE = 2'd1,   // field finished, value held
        PH_ERR  = 2'd2    // fifth byte asked for more
    } phase_e;

    // bytes needed to fill a value of the given width
    function automatic int bytes_for(input int width);
        return (width + GRP_W - 1) / GRP_W;
    endfunction

endpackage

// File: rtl/leb_accum.sv
`timescale 1ns/1ps
module leb_accum #(
    parameter int OUT_W = 32,
    parameter int SH_W  = 6,
    parameter int CNT_W = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic                   take,
    input  logic [leb_pkg::GRP_W-1:0] payload,
    output logic [OUT_W-1:0]       acc_nx,
    output logic [CNT_W-1:0]       cnt_q,
    output logic [CNT_W-1:0]       cnt_nx
);
    import leb_pkg::*;

    typedef struct packed {
        logic [OUT_W-1:0] acc;
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t st_q;

    // bits shifted past the top of the value fall away
    always_comb begin
        acc_nx = st_q.acc | (OUT_W'(payload) << st_q.sh);
        cnt_nx = st_q.cnt + CNT_W'(1);
    end

    assign cnt_q = st_q.cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= '0;
        end else if (take) begin
            st_q.acc <= acc_nx;
            st_q.sh  <= st_q.sh + SH_W'(GRP_W);
            st_q.cnt <= cnt_nx;
        end
    end

endmodule

// File: rtl/leb_extend.sv
`timescale 1ns/1ps
module leb_extend #(
    parameter int OUT_W = 32,
    parameter int CNT_W = 3,
    parameter int MAX_B = 5
) (
    input  logic [OUT_W-1:0] val,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             sgn,
    output logic [OUT_W-1:0] ext
);
    import leb_pkg::*;

    // one candidate per partial length; a full-length field is used as is
    logic [OUT_W-1:0] cand [1:MAX_B-1];

    for (genvar n = 1; n < MAX_B; n++) begin : g_len
        localparam int TOPB = GRP_W * n - 1;
        assign cand[n] = {{(OUT_W-TOPB-1){val[TOPB]}}, val[TOPB:0]};
    end

    always_comb begin
        ext = val;
        if (sgn) begin
            for (int n = 1; n < MAX_B; n++) begin
                if (nbytes == CNT_W'(n)) ext = cand[n];
            end
        end
    end

endmodule

// File: rtl/leb_ctrl.sv
`timescale 1ns/1ps
module leb_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic byte_vld,
    input  logic cont,
    input  logic last_slot,
    output logic take,
    output logic done,
    output logic ovf_err
);
    import leb_pkg::*;

    phase_e ph_q, ph_nx;
    logic   hit, ovf_hit;

    always_comb begin
        hit     = (ph_q == PH_RUN) && byte_vld && !clr;
        ovf_hit = hit && cont && last_slot;
        take    = hit && !ovf_hit;
        done    = hit && !cont;
        ph_nx   = ph_q;
        if (done)         ph_nx = PH_DONE;
        else if (ovf_hit) ph_nx = PH_ERR;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) ph_q <= PH_RUN;
        else            ph_q <= ph_nx;
    end

    assign ovf_err = (ph_q == PH_ERR);

endmodule

// File: rtl/leb_stream_dec.sv
`timescale 1ns/1ps
module leb_stream_dec #(
    parameter int OUT_W = 32,
    parameter int SH_W  = 6,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             sgn_mode,
    output logic             done,
    output logic [OUT_W-1:0] result,
    output logic             ovf_err
);
    import leb_pkg::*;

    localparam int MAX_B = bytes_for(OUT_W);

    logic             take;
    logic [OUT_W-1:0] acc_nx, ext, res_q;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             last_slot;

    assign last_slot = (cnt_q == CNT_W'(MAX_B - 1));

    leb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .byte_vld  (byte_vld),
        .cont      (byte_in[7]),
        .last_slot (last_slot),
        .take      (take),
        .done      (done),
        .ovf_err   (ovf_err)
    );

    leb_accum #(.OUT_W(OUT_W), .SH_W(SH_W), .CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .take    (take),
        .payload (byte_in[GRP_W-1:0]),
        .acc_nx  (acc_nx),
        .cnt_q   (cnt_q),
        .cnt_nx  (cnt_nx)
    );

    leb_extend #(.OUT_W(OUT_W), .CNT_W(CNT_W), .MAX_B(MAX_B)) u_ext (
        .val    (acc_nx),
        .nbytes (cnt_nx),
        .sgn    (sgn_mode),
        .ext    (ext)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) res_q <= '0;
        else if (done)  res_q <= ext;
    end

    assign result = done ? ext : res_q;

endmodule

// File: rtl/leb_stream_dec_chk.sv
`timescale 1ns/1ps
module leb_stream_dec_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             byte_vld,
    input logic             cont_bit,
    input logic             done,
    input logic [OUT_W-1:0] result,
    input logic             ovf_err
);

    a_r1_done_on_final_byte: assert property (@(posedge clk) disable iff (rst)
        done |-> (byte_vld && !cont_bit && !clr));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_result_hold: assert property (@(posedge clk) disable iff (rst)
        done |=> (result == $past(result)));

    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_err && !clr) |=> ovf_err);

    a_r5_no_done_in_err: assert property (@(posedge clk) disable iff (rst)
        ovf_err |-> !done);

    a_r7_clr_empties: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ovf_err && (done || result == '0)));

endmodule

bind leb_stream_dec leb_stream_dec_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .byte_vld (byte_vld),
    .cont_bit (byte_in[7]),
    .done     (done),
    .result   (result),
    .ovf_err  (ovf_err)
);

// File: tb/sim_leb_stream_dec.sv
`timescale 1ns/1ps
module sim_leb_stream_dec;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        sgn_mode = 1'b0;
    logic        done;
    logic [31:0] result;
    logic        ovf_err;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    leb_stream_dec u0 (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .byte_vld (byte_vld),
        .byte_in  (byte_in),
        .sgn_mode (sgn_mode),
        .done     (done),
        .result   (result),
        .ovf_err  (ovf_err)
    );

    // field bytes packed with the first byte in bits [7:0]
    localparam int NV = 14;
    localparam logic [39:0] VB [NV] = '{
        40'h2A, 40'h2A, 40'h7F, 40'h7F, 40'h0180, 40'h7FFF, 40'h7FFF,
        40'h408080, 40'h408080, 40'h40808080, 40'h7880808080,
        40'h0FFFFFFFFF, 40'h268EE5, 40'h7F80 };
    localparam int VN [NV] = '{1, 1, 1, 1, 2, 2, 2, 3, 3, 4, 5, 5, 3, 2};
    localparam bit VS [NV] = '{0, 1, 1, 0, 1, 1, 0, 1, 0, 1, 1, 0, 0, 1};
    localparam logic [31:0] VE [NV] = '{
        32'd42, 32'd42, 32'hFFFF_FFFF, 32'h0000_007F, 32'd128,
        32'hFFFF_FFFF, 32'h0000_3FFF, 32'hFFF0_0000, 32'h0010_0000,
        32'hF800_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0009_8765,
        32'hFFFF_FF80 };
    // requirement each vector exercises: R1 grouping, R2 signed,
    // R3 unsigned, R4 five-byte field
    localparam int VR [NV] = '{1, 2, 2, 3, 1, 2, 3, 2, 3, 2, 4, 4, 1, 2};

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic start_field(input bit sgn);
        @(negedge clk);
        clr = 1'b1; byte_vld = 1'b0; sgn_mode = sgn;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // present one byte, sample the combinational outputs, then let it be taken
    task automatic put(input logic [7:0] b);
        byte_vld = 1'b1; byte_in = b;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        check("R8 done", {31'd0, done}, 32'd0);
        check("R8 ovf_err", {31'd0, ovf_err}, 32'd0);
        check("R8 result", result, 32'd0);

        for (int v = 0; v < NV; v++) begin
            start_field(VS[v]);
            for (int i = 0; i < VN[v]; i++) begin
                put(VB[v][8*i +: 8]);
                if (i == VN[v] - 1) begin
                    check($sformatf("R%0d done vec%0d", VR[v], v), {31'd0, done}, 32'd1);
                    check($sformatf("R%0d result vec%0d", VR[v], v), result, VE[v]);
                end else begin
                    check($sformatf("R1 early done vec%0d", v), {31'd0, done}, 32'd0);
                end
                @(negedge clk);
            end
            byte_vld = 1'b0;
            #1;
            check($sformatf("R6 hold vec%0d", v), result, VE[v]);
        end

        // R5: fifth byte with continuation
        start_field(1'b0);
        for (int i = 0; i < 4; i++) begin
            put(8'h80);
            @(negedge clk);
        end
        put(8'h81);
        check("R5 no done on bad fifth byte", {31'd0, done}, 32'd0);
        @(negedge clk);
        byte_vld = 1'b0;
        #1;
        check("R5 ovf_err raised", {31'd0, ovf_err}, 32'd1);
        @(negedge clk);
        put(8'h05);
        check("R5 no done after error", {31'd0, done}, 32'd0);
        @(negedge clk);
        byte_vld = 1'b0;
        #1;
        check("R5 ovf_err sticky", {31'd0, ovf_err}, 32'd1);
        start_field(1'b0);
        #1;
        check("R7 clr drops ovf_err", {31'd0, ovf_err}, 32'd0);
        check("R7 clr zeroes result", result, 32'd0);

        // R6: bytes after done are ignored
        put(8'h15);
        check("R6 done", {31'd0, done}, 32'd1);
        @(negedge clk);
        put(8'h33);
        check("R6 no second done", {31'd0, done}, 32'd0);
        check("R6 result kept", result, 32'h15);
        idle();
        #1;
        check("R6 result still kept", result, 32'h15);

        // R7: byte together with clr is discarded; idle cycles are harmless
        @(negedge clk);
        clr = 1'b1; byte_vld = 1'b1; byte_in = 8'h81; sgn_mode = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        put(8'h03);
        check("R7 byte with clr discarded", result, 32'h03);
        @(negedge clk);
        start_field(1'b0);
        put(8'h81);
        @(negedge clk);
        byte_vld = 1'b0; byte_in = 8'h7F;
        repeat (2) @(negedge clk);
        put(8'h01);
        check("R7 gap done", {31'd0, done}, 32'd1);
        check("R7 gap result", result, 32'h81);
        idle();

        finish_up();
    end

endmodule